// File: doc/BRIEF.md
# Serial flash command sequencer

This block runs complete operations on an SPI serial configuration flash for a host. The host posts one request at a time: an operation code, a 24-bit flash address (or, for erase, a first sector index), a length and, for a status write, the value to write. The block then frames every transaction with chip select, sends the opcode and any address bytes, and moves payload bytes to or from a RAM-like host buffer port. Write-type operations are wrapped in their own write-enable transaction and followed by status polling until the device reports that it is idle.

Long program requests are cut into chunks that never cross a flash page. Multi-sector erases become one sector-erase command per sector. Payload bytes travel bit-reversed on the wire, so that bit 0 of a host byte is the first bit shifted. Opcode, address, dummy, ID and status bytes are sent and returned unchanged. The SPI clock is fixed at half the system clock, in mode 0. Page and sector sizes are log2 parameters.

Top module: `sflash_seq`

## Requirements
- R1: A read (req_op_i=0), program (1) or sector erase (2) frame sends its opcode (0x03, 0x02, 0xD8) and then three address bytes with the most significant byte first.
- R2: A read-ID request (req_op_i=3) sends 0xAB and three zero bytes, clocks one more byte, and returns that byte unreversed on rsp_data_o.
- R3: Every program chunk, sector erase, status write and bulk erase is preceded by its own chip-select-framed write-enable frame (0x06). Reads, read-ID and read-status send no write enable.
- R4: After every program chunk, sector erase, status write and bulk erase, the block sends status-read frames (0x05, one returned byte) until bit 0 of the returned status (write in progress) is 0. Only then does it send any further frame or finish.
- R5: A program request at offset A of N bytes is split into frames of which none crosses a page of 2^PAGE_LOG2 bytes. The first frame has min(page size - (A mod page size), N) bytes, and each later frame starts at the next page.
- R6: Payload bytes of reads and programs are bit-reversed between the host buffer and the wire. Host byte index k of a request maps to flash address A+k.
- R7: A sector erase request (req_op_i=2) with first sector S in req_addr_i and count C in req_len_i sends C sector-erase frames at addresses S, S+1, ... times 2^SECT_LOG2. Sectors outside the range are left untouched.
- R8: SPI mode 0 with sclk low while idle. Chip select rises only after the last bit of a frame has shifted out, so every frame holds whole bytes.
- R9: busy_o is high from the cycle after acceptance until the cycle after the one-cycle done_o pulse. req_ready_o is low while busy, and a request presented then is ignored.
- R10: A read, program or erase with length 0 completes with done_o and sends no frame.
- R11: A status read (req_op_i=4) returns the device status byte unreversed. A status write (req_op_i=5) sends 0x01 followed by req_stat_i unreversed.
- R12: A bulk erase (req_op_i=6) sends the single byte 0xC7 in its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken when valid |
| req_op_i | input | 3 | Operation code (0 read .. 6 bulk erase) |
| req_addr_i | input | 24 | Flash byte address, or first sector index for erase |
| req_len_i | input | LEN_W | Byte count, or sector count for erase |
| req_stat_i | input | 8 | Value for a status write |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rsp_data_o | output | 8 | Returned ID or status byte |
| buf_addr_o | output | LEN_W | Host buffer byte index |
| buf_rdata_i | input | 8 | Host buffer read data, same cycle |
| buf_we_o | output | 1 | Host buffer write strobe |
| buf_wdata_o | output | 8 | Host buffer write data |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
The program path is driven with a 40-byte request at an unaligned offset, with 16-byte pages. This separates a correct first chunk from one that ignores the offset, and a correct last chunk from one that runs past the count. A read-back of the same range against non-palindromic data separates payload reversal from none, and a reversed status and ID value shows that header bytes stay raw. The device model reports busy for several polls, so a block that stops polling early or skips write enable shows up in the logged frame order. Zero-length requests and a request presented while busy separate real work from spurious frames.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  localparam logic [7:0] OPC_WR_EN      = 8'h06;
  localparam logic [7:0] OPC_WR_DIS     = 8'h04;
  localparam logic [7:0] OPC_STAT_RD    = 8'h05;
  localparam logic [7:0] OPC_DATA_RD    = 8'h03;
  localparam logic [7:0] OPC_ID_RD      = 8'hAB;
  localparam logic [7:0] OPC_STAT_WR    = 8'h01;
  localparam logic [7:0] OPC_PAGE_PGM   = 8'h02;
  localparam logic [7:0] OPC_CHIP_ERASE = 8'hC7;
  localparam logic [7:0] OPC_SECT_ERASE = 8'hD8;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_WEL_BIT  = 1;

  typedef enum logic [2:0] {
    REQ_READ       = 3'd0,
    REQ_PROG       = 3'd1,
    REQ_ERASE      = 3'd2,
    REQ_ID         = 3'd3,
    REQ_STAT_RD    = 3'd4,
    REQ_STAT_WR    = 3'd5,
    REQ_CHIP_ERASE = 3'd6
  } req_op_e;

  typedef enum logic [1:0] {
    FRM_WEN  = 2'd0,
    FRM_MAIN = 2'd1,
    FRM_POLL = 2'd2
  } frm_e;

  function automatic logic [7:0] bit_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/sflash_shift.sv
module sflash_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       idle_o
);
  logic       active_q, phase_q, sclk_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      sclk_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      sh_q     <= tx_i;
    end else if (active_q) begin
      if (!phase_q) begin
        sclk_q  <= 1'b1;
        rx_q    <= {rx_q[6:0], miso_i};
        phase_q <= 1'b1;
      end else begin
        sclk_q  <= 1'b0;
        phase_q <= 1'b0;
        sh_q    <= {sh_q[6:0], 1'b0};
        bit_q   <= bit_q + 3'd1;
        if (bit_q == 3'd7) active_q <= 1'b0;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[7];
  assign rx_o   = rx_q;
  assign done_o = active_q & phase_q & (bit_q == 3'd7);
  assign idle_o = ~active_q;

  // R8: clock parks low between bytes
  a_r8_sclk_parks_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sclk_q);

  // R8: a byte always has eight rising edges before idle
  a_r8_whole_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(bit_q) == 3'd7));

endmodule

// File: rtl/sflash_chunk.sv
module sflash_chunk #(
  parameter int unsigned PAGE_LOG2 = 8,
  parameter int unsigned LEN_W     = 16
) (
  input  logic [PAGE_LOG2-1:0] off_i,
  input  logic [LEN_W-1:0]     rem_i,
  output logic [LEN_W-1:0]     chunk_o
);
  localparam logic [LEN_W:0] PAGE_SPAN = (LEN_W+1)'(1) << PAGE_LOG2;

  logic [LEN_W:0] room;

  assign room    = PAGE_SPAN - (LEN_W+1)'(off_i);
  assign chunk_o = ({1'b0, rem_i} < room) ? rem_i : room[LEN_W-1:0];

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq #(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned PAGE_LOG2 = 8,
  parameter int unsigned SECT_LOG2 = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_op_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       req_stat_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rsp_data_o,
  output logic [LEN_W-1:0] buf_addr_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o,
  output logic             spi_sclk_o,
  output logic             spi_cs_no,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i
);
  import sflash_pkg::*;

  localparam int unsigned ADDR_W     = 24;
  localparam logic [ADDR_W-1:0] SECT_BYTES = ADDR_W'(1) << SECT_LOG2;
  localparam logic [LEN_W:0]    PAGE_SPAN  = (LEN_W+1)'(1) << PAGE_LOG2;

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_CSLO, S_LOAD, S_WAIT, S_CSHI, S_NEXT, S_FIN
  } state_e;

  state_e            state_q;
  req_op_e           op_q;
  frm_e              frm_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, base_q, chunk_q, pay_q;
  logic [LEN_W:0]    idx_q;
  logic [7:0]        wsr_q, rsp_q;
  logic              cs_q, poll_busy_q, wen_q;

  logic              sh_start, sh_done, sh_idle;
  logic [7:0]        sh_rx, tx_byte, opcode;
  logic [LEN_W-1:0]  chunk, main_pay, pay_idx;
  logic [2:0]        hdr_len;
  logic [LEN_W:0]    total;
  logic              in_pay, last_byte, is_wr, has_len;

  sflash_chunk #(.PAGE_LOG2(PAGE_LOG2), .LEN_W(LEN_W)) u_chunk (
    .off_i   (addr_q[PAGE_LOG2-1:0]),
    .rem_i   (rem_q),
    .chunk_o (chunk)
  );

  sflash_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .tx_i    (tx_byte),
    .miso_i  (spi_miso_i),
    .sclk_o  (spi_sclk_o),
    .mosi_o  (spi_mosi_o),
    .rx_o    (sh_rx),
    .done_o  (sh_done),
    .idle_o  (sh_idle)
  );

  always_comb begin
    is_wr   = (op_q == REQ_PROG) || (op_q == REQ_ERASE) ||
              (op_q == REQ_STAT_WR) || (op_q == REQ_CHIP_ERASE);
    has_len = (op_q == REQ_READ) || (op_q == REQ_PROG) || (op_q == REQ_ERASE);
    case (op_q)
      REQ_READ:                         main_pay = rem_q;
      REQ_PROG:                         main_pay = chunk;
      REQ_ID, REQ_STAT_RD, REQ_STAT_WR: main_pay = LEN_W'(1);
      default:                          main_pay = '0;
    endcase
  end

  // frame header length and opcode
  always_comb begin
    hdr_len = 3'd1;
    opcode  = OPC_STAT_RD;
    case (frm_q)
      FRM_WEN:  opcode = OPC_WR_EN;
      FRM_POLL: opcode = OPC_STAT_RD;
      default: begin
        case (op_q)
          REQ_READ:       begin opcode = OPC_DATA_RD;    hdr_len = 3'd4; end
          REQ_PROG:       begin opcode = OPC_PAGE_PGM;   hdr_len = 3'd4; end
          REQ_ERASE:      begin opcode = OPC_SECT_ERASE; hdr_len = 3'd4; end
          REQ_ID:         begin opcode = OPC_ID_RD;      hdr_len = 3'd4; end
          REQ_STAT_WR:    opcode = OPC_STAT_WR;
          REQ_CHIP_ERASE: opcode = OPC_CHIP_ERASE;
          default:        opcode = OPC_STAT_RD;
        endcase
      end
    endcase
  end

  assign total     = {1'b0, pay_q} + (LEN_W+1)'(hdr_len);
  assign in_pay    = idx_q >= (LEN_W+1)'(hdr_len);
  assign last_byte = (idx_q + 1'b1) == total;
  assign pay_idx   = LEN_W'(idx_q - (LEN_W+1)'(hdr_len));

  always_comb begin
    tx_byte = 8'h00;
    if (idx_q == '0) begin
      tx_byte = opcode;
    end else if (!in_pay) begin
      if (op_q != REQ_ID) begin
        case (idx_q[1:0])
          2'd1:    tx_byte = addr_q[23:16];
          2'd2:    tx_byte = addr_q[15:8];
          default: tx_byte = addr_q[7:0];
        endcase
      end
    end else if (frm_q == FRM_MAIN) begin
      if (op_q == REQ_PROG)         tx_byte = bit_rev8(buf_rdata_i);
      else if (op_q == REQ_STAT_WR) tx_byte = wsr_q;
    end
  end

  assign sh_start    = (state_q == S_LOAD);
  assign buf_addr_o  = base_q + pay_idx;
  assign buf_we_o    = (state_q == S_WAIT) && sh_done && in_pay &&
                       (frm_q == FRM_MAIN) && (op_q == REQ_READ);
  assign buf_wdata_o = bit_rev8(sh_rx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= REQ_READ;
      frm_q       <= FRM_WEN;
      addr_q      <= '0;
      rem_q       <= '0;
      base_q      <= '0;
      chunk_q     <= '0;
      pay_q       <= '0;
      idx_q       <= '0;
      wsr_q       <= '0;
      rsp_q       <= '0;
      cs_q        <= 1'b1;
      poll_busy_q <= 1'b0;
      wen_q       <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          op_q   <= req_op_e'(req_op_i);
          addr_q <= (req_op_e'(req_op_i) == REQ_ERASE) ? (req_addr_i << SECT_LOG2)
                                                       : req_addr_i;
          rem_q  <= req_len_i;
          base_q <= '0;
          wsr_q  <= req_stat_i;
          state_q <= S_PLAN;
        end
        S_PLAN: begin
          if (has_len && rem_q == '0) begin
            state_q <= S_FIN;
          end else if (is_wr) begin
            frm_q   <= FRM_WEN;
            pay_q   <= '0;
            state_q <= S_CSLO;
          end else begin
            frm_q   <= FRM_MAIN;
            pay_q   <= main_pay;
            chunk_q <= chunk;
            state_q <= S_CSLO;
          end
        end
        S_CSLO: begin
          cs_q    <= 1'b0;
          idx_q   <= '0;
          state_q <= S_LOAD;
        end
        S_LOAD: state_q <= S_WAIT;
        S_WAIT: if (sh_done) begin
          if (in_pay) begin
            if (frm_q == FRM_POLL) poll_busy_q <= sh_rx[STAT_BUSY_BIT];
            if (frm_q == FRM_MAIN && (op_q == REQ_ID || op_q == REQ_STAT_RD))
              rsp_q <= sh_rx;
          end
          if (last_byte) state_q <= S_CSHI;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_LOAD;
          end
        end
        S_CSHI: if (sh_idle) begin
          cs_q    <= 1'b1;
          state_q <= S_NEXT;
        end
        S_NEXT: begin
          case (frm_q)
            FRM_WEN: begin
              wen_q   <= 1'b1;
              frm_q   <= FRM_MAIN;
              pay_q   <= main_pay;
              chunk_q <= chunk;
              state_q <= S_CSLO;
            end
            FRM_MAIN: begin
              wen_q <= 1'b0;
              if (is_wr) begin
                frm_q   <= FRM_POLL;
                pay_q   <= LEN_W'(1);
                state_q <= S_CSLO;
              end else begin
                state_q <= S_FIN;
              end
            end
            default: begin
              if (poll_busy_q) begin
                state_q <= S_CSLO;
              end else begin
                case (op_q)
                  REQ_PROG: begin
                    addr_q  <= addr_q + ADDR_W'(chunk_q);
                    rem_q   <= rem_q - chunk_q;
                    base_q  <= base_q + chunk_q;
                    state_q <= S_PLAN;
                  end
                  REQ_ERASE: begin
                    addr_q  <= addr_q + SECT_BYTES;
                    rem_q   <= rem_q - LEN_W'(1);
                    state_q <= S_PLAN;
                  end
                  default: state_q <= S_FIN;
                endcase
              end
            end
          endcase
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign spi_cs_no   = cs_q;
  assign req_ready_o = (state_q == S_IDLE);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_FIN);
  assign rsp_data_o  = rsp_q;

  // R8: chip select rises only with the shifter empty
  a_r8_cs_rise_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> sh_idle);

  // R8: no clock while deselected
  a_r8_no_clk_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);

  // R9: busy ends only right after the done pulse
  a_r9_busy_ends_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));

  // R3: a write-type main frame follows a write-enable frame
  a_r3_wen_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CSLO && frm_q == FRM_MAIN && is_wr) |-> wen_q);

  // R5: program chunk is non-empty and stays inside its page
  a_r5_chunk_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CSLO && frm_q == FRM_MAIN && op_q == REQ_PROG) |->
    (chunk_q != '0 &&
     ((LEN_W+1)'(addr_q[PAGE_LOG2-1:0]) + {1'b0, chunk_q}) <= PAGE_SPAN));

  // R4: progress only after a poll that saw the device idle
  a_r4_advance_after_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q != $past(rem_q)) |->
    ($past(state_q) == S_IDLE ||
     ($past(state_q) == S_NEXT && $past(frm_q) == FRM_POLL && !$past(poll_busy_q))));

endmodule

// File: tb/sim_sflash_seq.sv
`timescale 1ns/1ps
module sim_sflash_seq;
  localparam int unsigned LEN_W = 16;
  localparam int unsigned PG    = 4;   // 16-byte pages
  localparam int unsigned SC    = 8;   // 256-byte sectors
  localparam logic [7:0]  ID_CODE = 8'h13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] req_stat = '0;
  logic busy, done;
  logic [7:0] rsp;
  logic [LEN_W-1:0] buf_addr;
  logic [7:0] buf_rdata, buf_wdata;
  logic buf_we;
  logic sclk, cs_n, mosi, miso = 1'b0;

  always #4 clk = ~clk;

  sflash_seq #(.LEN_W(LEN_W), .PAGE_LOG2(PG), .SECT_LOG2(SC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_len_i(req_len), .req_stat_i(req_stat),
    .busy_o(busy), .done_o(done), .rsp_data_o(rsp), .buf_addr_o(buf_addr),
    .buf_rdata_i(buf_rdata), .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso));

  // host buffer
  logic [7:0] hbuf [0:255];
  assign buf_rdata = hbuf[buf_addr[7:0]];
  always @(posedge clk) if (buf_we) hbuf[buf_addr[7:0]] <= buf_wdata;

  // flash model
  logic [7:0] dmem [0:1023];
  logic [7:0] dstat = 8'h00;
  logic [7:0] fb [0:35];
  logic [7:0] shin, outb;
  logic [7:0] op_log [0:255];
  int bitc, bytec, wip_left;
  int n_frames, partial_cnt, wel_err, cross_err, busy_err;
  int pp_n, se_n, id_len, rd_len;
  int pp_addr [0:15], pp_len [0:15], se_addr [0:15];
  int rd_addr;
  logic id_dummy_ok;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic int fr_addr();
    return {8'h00, fb[1], fb[2], fb[3]};
  endfunction

  always @(negedge cs_n) begin
    bitc = 0; bytec = 0; outb = 8'h00; miso = 1'b0;
  end

  always @(posedge sclk) if (!cs_n) begin
    shin = {shin[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec < 36) fb[bytec] = shin;
      bytec++;
      outb = 8'h00;
      if (fb[0] == 8'h05 && bytec >= 1) outb = dstat;
      if (fb[0] == 8'hAB && bytec >= 4) outb = ID_CODE;
      if (fb[0] == 8'h03 && bytec >= 4) outb = dmem[(fr_addr() + bytec - 4) % 1024];
    end
  end

  always @(negedge sclk) if (!cs_n) miso = outb[7-bitc];

  always @(posedge cs_n) if (bytec > 0) begin
    if (bitc != 0) partial_cnt++;
    if (n_frames < 256) op_log[n_frames] = fb[0];
    n_frames++;
    if (dstat[0] && fb[0] != 8'h05) busy_err++;
    case (fb[0])
      8'h06: dstat[1] = 1'b1;
      8'h05: if (wip_left > 0) begin
        wip_left--;
        if (wip_left == 0) dstat[0] = 1'b0;
      end
      8'h02: if (!dstat[1]) wel_err++; else begin
        if (pp_n < 16) begin pp_addr[pp_n] = fr_addr(); pp_len[pp_n] = bytec - 4; end
        pp_n++;
        if ((fr_addr() % 16) + bytec - 4 > 16) cross_err++;
        for (int i = 0; i < bytec - 4; i++) dmem[(fr_addr() + i) % 1024] = fb[4+i];
        dstat[1:0] = 2'b01; wip_left = 3;
      end
      8'hD8: if (!dstat[1]) wel_err++; else begin
        if (se_n < 16) se_addr[se_n] = fr_addr();
        se_n++;
        for (int i = 0; i < 256; i++) dmem[((fr_addr() & ~255) + i) % 1024] = 8'hFF;
        dstat[1:0] = 2'b01; wip_left = 2;
      end
      8'h01: if (!dstat[1]) wel_err++; else begin
        dstat = {fb[1][7:2], 2'b01}; wip_left = 1;
      end
      8'hC7: if (!dstat[1]) wel_err++; else begin
        for (int i = 0; i < 1024; i++) dmem[i] = 8'hFF;
        dstat[1:0] = 2'b01; wip_left = 2;
      end
      8'hAB: begin
        id_len = bytec;
        id_dummy_ok = (fb[1] == 8'h00) && (fb[2] == 8'h00) && (fb[3] == 8'h00);
      end
      8'h03: begin rd_addr = fr_addr(); rd_len = bytec - 4; end
      default: ;
    endcase
  end

  // checking
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_op(input int idx, input logic [7:0] exp, input string tag);
    chk(op_log[idx] == exp, tag, op_log[idx], exp);
  endtask

  task automatic send(input logic [2:0] op, input logic [23:0] a,
                      input logic [LEN_W-1:0] len, input logic [7:0] st);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_len = len; req_stat = st; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    bit busy_ok = 1;
    while (!done && n < 20000) begin
      if (!busy) busy_ok = 0;
      @(negedge clk); n++;
    end
    chk(busy_ok, {tag, " R9 busy held until done"}, busy_ok, 1);
    chk(done, {tag, " R9 done pulse"}, done, 1);
    @(negedge clk);
    chk(!done && !busy, {tag, " R9 done one cycle then idle"}, {done, busy}, 0);
  endtask

  task automatic run(input logic [2:0] op, input logic [23:0] a,
                     input logic [LEN_W-1:0] len, input logic [7:0] st, input string tag);
    send(op, a, len, st);
    wait_done(tag);
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1, "R8 reset cs high", cs_n, 1);
    chk(sclk == 1'b0, "R8 reset sclk low", sclk, 0);
    chk(!busy && req_ready, "R9 reset idle", {busy, req_ready}, 1);
  endtask

  task automatic t_id();
    int f0 = n_frames;
    run(3, 24'h0, '0, 8'h0, "id");
    chk(rsp == ID_CODE, "R2 id byte raw", rsp, ID_CODE);
    chk(id_len == 5, "R2 id frame length", id_len, 5);
    chk(id_dummy_ok, "R2 dummy bytes zero", id_dummy_ok, 1);
    chk(n_frames == f0 + 1, "R3 no write enable on id", n_frames - f0, 1);
  endtask

  task automatic t_stat();
    int f0;
    dstat = 8'h0C;
    run(4, 24'h0, '0, 8'h0, "rdsr");
    chk(rsp == 8'h0C, "R11 status read raw", rsp, 8'h0C);
    f0 = n_frames;
    run(5, 24'h0, '0, 8'h70, "wrsr");
    chk(n_frames == f0 + 4, "R4 wrsr frame count", n_frames - f0, 4);
    chk_op(f0,   8'h06, "R3 wrsr write enable");
    chk_op(f0+1, 8'h01, "R11 wrsr opcode");
    chk_op(f0+2, 8'h05, "R4 wrsr poll");
    run(4, 24'h0, '0, 8'h0, "rdsr2");
    chk(rsp == 8'h70, "R11 status written raw", rsp, 8'h70);
    dstat = 8'h00;
  endtask

  task automatic t_prog();
    int f0 = n_frames;
    int ea [4] = '{'h0B, 'h10, 'h20, 'h30};
    int el [4] = '{5, 16, 16, 3};
    bit mem_ok = 1;
    bit seq_ok = 1;
    pp_n = 0;
    for (int i = 0; i < 40; i++) hbuf[i] = 8'((i * 37 + 5) & 255);
    run(1, 24'h00000B, 16'd40, 8'h0, "prog");
    chk(pp_n == 4, "R5 chunk count", pp_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk(pp_addr[k] == ea[k], "R1 R5 chunk address", pp_addr[k], ea[k]);
      chk(pp_len[k] == el[k], "R5 chunk length", pp_len[k], el[k]);
    end
    for (int i = 0; i < 40; i++)
      if (dmem[11+i] != rev8(hbuf[i])) mem_ok = 0;
    chk(mem_ok, "R6 programmed bytes reversed", mem_ok, 1);
    for (int k = 0; k < 4; k++) begin
      if (op_log[f0+6*k] != 8'h06 || op_log[f0+6*k+1] != 8'h02) seq_ok = 0;
      for (int j = 2; j < 6; j++) if (op_log[f0+6*k+j] != 8'h05) seq_ok = 0;
    end
    chk(seq_ok, "R3 R4 enable-program-poll order", seq_ok, 1);
    chk(n_frames == f0 + 24, "R4 polls until idle", n_frames - f0, 24);
    chk(cross_err == 0, "R5 no page crossing", cross_err, 0);
  endtask

  task automatic t_read();
    bit ok = 1;
    for (int i = 0; i < 40; i++) hbuf[i] = 8'h00;
    run(0, 24'h00000B, 16'd40, 8'h0, "read");
    for (int i = 0; i < 40; i++)
      if (hbuf[i] != 8'((i * 37 + 5) & 255)) ok = 0;
    chk(ok, "R6 read bytes reversed back", ok, 1);
    chk(rd_addr == 'h0B, "R1 read address msb first", rd_addr, 'h0B);
    chk(rd_len == 40, "R1 read length", rd_len, 40);
  endtask

  task automatic t_erase();
    int f0 = n_frames;
    bit ok = 1;
    se_n = 0;
    run(2, 24'd1, 16'd2, 8'h0, "erase");
    chk(se_n == 2, "R7 sector command count", se_n, 2);
    chk(se_addr[0] == 'h100, "R7 first sector address", se_addr[0], 'h100);
    chk(se_addr[1] == 'h200, "R7 second sector address", se_addr[1], 'h200);
    for (int i = 'h100; i < 'h300; i++) if (dmem[i] != 8'hFF) ok = 0;
    chk(ok, "R7 sectors erased", ok, 1);
    chk(dmem[11] == rev8(8'd5), "R7 sector 0 untouched", dmem[11], rev8(8'd5));
    chk_op(f0,   8'h06, "R3 erase enable");
    chk_op(f0+1, 8'hD8, "R1 erase opcode");
    chk_op(f0+4, 8'h05, "R4 erase poll");
    chk_op(f0+5, 8'h06, "R3 second erase enable");
  endtask

  task automatic t_zero();
    int f0 = n_frames;
    run(0, 24'h10, '0, 8'h0, "zread");
    run(1, 24'h10, '0, 8'h0, "zprog");
    run(2, 24'h1, '0, 8'h0, "zerase");
    chk(n_frames == f0, "R10 zero length sends nothing", n_frames - f0, 0);
  endtask

  task automatic t_ignore();
    int f0 = n_frames;
    bit no_bulk = 1;
    bit ok = 1;
    send(0, 24'h000100, 16'd4, 8'h0);
    repeat (20) @(negedge clk);
    chk(!req_ready, "R9 not ready while busy", req_ready, 0);
    req_op = 3'd6; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("ignore");
    repeat (100) @(negedge clk);
    for (int i = f0; i < n_frames; i++) if (op_log[i] == 8'hC7) no_bulk = 0;
    chk(no_bulk && !busy, "R9 request while busy ignored", no_bulk, 1);
    for (int i = 0; i < 4; i++) if (hbuf[i] != 8'hFF) ok = 0;
    chk(ok, "R6 read erased data", ok, 1);
  endtask

  task automatic t_bulk();
    int f0 = n_frames;
    bit ok = 1;
    run(6, 24'h0, '0, 8'h0, "bulk");
    chk_op(f0,   8'h06, "R3 bulk enable");
    chk_op(f0+1, 8'hC7, "R12 bulk opcode");
    chk(n_frames == f0 + 5, "R4 bulk polls", n_frames - f0, 5);
    for (int i = 0; i < 1024; i++) if (dmem[i] != 8'hFF) ok = 0;
    chk(ok, "R12 device erased", ok, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) dmem[i] = 8'h00;
    for (int i = 0; i < 256; i++) hbuf[i] = 8'h00;
    n_frames = 0; partial_cnt = 0; wel_err = 0; cross_err = 0; busy_err = 0;
    pp_n = 0; se_n = 0; wip_left = 0; id_len = 0; rd_len = 0; rd_addr = 0;
    id_dummy_ok = 1'b0; bitc = 0; bytec = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_id();
    t_stat();
    t_prog();
    t_read();
    t_erase();
    t_zero();
    t_ignore();
    t_bulk();
    chk(partial_cnt == 0, "R8 whole-byte frames", partial_cnt, 0);
    chk(wel_err == 0, "R3 write enable latched", wel_err, 0);
    chk(busy_err == 0, "R4 no command while device busy", busy_err, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule